// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt events for a small processor. The events come from external pins, from single-cycle strobes raised by on-chip peripherals, and from a software break strobe. Each pin and each peripheral strobe has its own latched request bit and its own enable bit. A single global disable flag gates all of them. The software break has no request or enable bit. It is held in a hidden latch and ignores both the enables and the disable flag.

External pins pass through a synchronizer and then an edge detector. Four of the pins have a programmable active edge. The rest always react to a rising edge. Among the pending sources, a fixed priority picks one winner. When the processor pulses its accept strobe, the block clears the winner's request bit and sets the disable flag. On the next cycle it raises a one-cycle take pulse together with the winner's vector index.

Software reaches the enable bits, the request bits, the edge-select bits and the disable flag through a small register port. Writes take effect on the next clock edge, and reads are combinational.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all enable bits, request bits and edge-select bits read 0, the disable flag reads 1, and irq_pend_o and irq_take_o are 0.
- R2: A one-cycle pulse on int_evt_i[k] sets request bit 5+k, read at address 1. The bit is readable one clock edge after the pulse.
- R3: A pin event on ext_pin_i[p] sets request bit p on the third rising clock edge after the pin changes. Edge-select bit p at address 2 chooses the event: 0 selects a rising edge and 1 selects a falling edge. The opposite transition sets nothing.
- R4: Writing address 1 clears each request bit whose data bit is 0. Data bits of 1 leave the request bits unchanged, so software cannot set a request.
- R5: When a hardware event and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R6: irq_pend_o is 1 when the break latch is set. Otherwise it is 1 only when some request bit and its matching enable bit (address 0, same position) are both 1 and the disable flag (address 3, bit 0) is 0.
- R7: Priority runs from the break (vector 0) first, then from the lowest set masked request index k (vector k+1).
- R8: If cpu_ack_i is high while irq_pend_o is high, then at that clock edge the winner's request is cleared and the disable flag is set. In the following cycle irq_take_o is high for exactly one cycle and irq_vec_o carries the winner's vector.
- R9: Writing a new edge-select value can set the matching request bit by itself. With the pin held low, switching its edge-select bit from 0 to 1 sets the request bit two clock edges after the write.
- R10: cpu_ack_i while irq_pend_o is 0 produces no take pulse and changes neither the request bits nor the disable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | N_EXT (5) | Asynchronous external interrupt pins |
| int_evt_i | input | N_INT (18) | Synchronous peripheral event strobes |
| brk_i | input | 1 | Software break strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select: 0 enables, 1 requests, 2 edge selects, 3 disable flag |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data, combinational |
| cpu_ack_i | input | 1 | Processor accept strobe |
| irq_pend_o | output | 1 | An unmasked interrupt is waiting |
| irq_take_o | output | 1 | One-cycle pulse after an accept |
| irq_vec_o | output | 5 | Vector index of the accepted source |

## Verification
Each result has a fixed latency from its stimulus. A peripheral strobe or a register write is visible one edge later. A pin change reaches its request bit on the third edge. A spurious request after an edge-select write appears on the second edge. The take pulse and its vector follow the edge that sampled the accept. The bench drives every input on a falling clock edge and counts whole falling edges to the cycle where each result is due. It checks that cycle and, for the pin path, the cycle just before it, so that both an early result and a late one are caught. For the "no effect" cases, it reads the request and flag registers back through the register port after the stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      RA_ENABLE  = 2'd0,
      RA_REQUEST = 2'd1,
      RA_EDGE    = 2'd2,
      RA_CTRL    = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int N_PIN = 5,
   parameter int N_SEL = 4,
   parameter int SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_PIN-1:0] pin_i,
   input  logic [N_SEL-1:0] pol_i,
   output logic [N_PIN-1:0] edge_o
);
   if (SYNC < 2) begin : g_bad_sync
      $error("irq_edge_det: SYNC must be at least 2");
   end

   for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      logic [SYNC-1:0] sh_q;
      logic            pol;
      logic            eff;
      logic            eff_q;

      if (p < N_SEL) begin : g_sel
         assign pol = pol_i[p];
      end else begin : g_fix
         assign pol = 1'b0;
      end

      // active level under the current polarity; a polarity change alone may look like an edge
      assign eff = sh_q[SYNC-1] ^ pol;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= '0;
            eff_q <= 1'b0;
         end else begin
            sh_q  <= {sh_q[SYNC-2:0], pin_i[p]};
            eff_q <= eff;
         end
      end

      assign edge_o[p] = eff & ~eff_q;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int W  = 23,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N_EXT = 5,
   parameter int N_INT = 18,
   parameter int N_SEL = 4,
   parameter int SYNC  = 2,
   parameter int DW    = 32,
   localparam int NSRC  = N_EXT + N_INT,
   localparam int VEC_W = $clog2(NSRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_pin_i,
   input  logic [N_INT-1:0] int_evt_i,
   input  logic             brk_i,
   input  logic             reg_we_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [DW-1:0]    reg_wdata_i,
   output logic [DW-1:0]    reg_rdata_o,
   input  logic             cpu_ack_i,
   output logic             irq_pend_o,
   output logic             irq_take_o,
   output logic [VEC_W-1:0] irq_vec_o
);
   import irq_pkg::*;

   localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC > DW) begin : g_bad_dw
      $error("irq_arbiter: DW too narrow for the source count");
   end
   if (N_SEL < 1 || N_SEL > N_EXT) begin : g_bad_sel
      $error("irq_arbiter: N_SEL must lie in 1..N_EXT");
   end

   logic [NSRC-1:0]  req_q, en_q, hw_set, sw_clr, take_clr;
   logic [N_SEL-1:0] sel_q;
   logic [N_EXT-1:0] ext_edge;
   logic             i_flag_q, brk_q;
   logic             found, accept;
   logic [IW-1:0]    win_idx;
   logic             wr_en, wr_req, wr_sel, wr_ctl;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata_i;

   irq_edge_det #(.N_PIN(N_EXT), .N_SEL(N_SEL), .SYNC(SYNC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pin_i),
      .pol_i  (sel_q),
      .edge_o (ext_edge)
   );

   irq_prio_enc #(.W(NSRC)) u_enc (
      .req_i   (req_q & en_q),
      .found_o (found),
      .idx_o   (win_idx)
   );

   assign hw_set = {int_evt_i, ext_edge};

   assign wr_en  = reg_we_i && (reg_addr_i == RA_ENABLE);
   assign wr_req = reg_we_i && (reg_addr_i == RA_REQUEST);
   assign wr_sel = reg_we_i && (reg_addr_i == RA_EDGE);
   assign wr_ctl = reg_we_i && (reg_addr_i == RA_CTRL);

   assign sw_clr     = wr_req ? ~reg_wdata_i[NSRC-1:0] : '0;
   assign irq_pend_o = brk_q | (~i_flag_q & found);
   assign accept     = cpu_ack_i & irq_pend_o;
   assign take_clr   = (accept && !brk_q && found) ? (NSRC'(1) << win_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         en_q       <= '0;
         sel_q      <= '0;
         i_flag_q   <= 1'b1;
         brk_q      <= 1'b0;
         irq_take_o <= 1'b0;
         irq_vec_o  <= '0;
      end else begin
         // hardware set overrides both clear paths
         req_q <= (req_q & ~sw_clr & ~take_clr) | hw_set;
         if (wr_en)  en_q  <= reg_wdata_i[NSRC-1:0];
         if (wr_sel) sel_q <= reg_wdata_i[N_SEL-1:0];
         if (accept)      i_flag_q <= 1'b1;
         else if (wr_ctl) i_flag_q <= reg_wdata_i[0];
         brk_q      <= brk_i | (brk_q & ~accept);
         irq_take_o <= accept;
         if (accept) begin
            irq_vec_o <= brk_q ? '0 : (VEC_W'(win_idx) + VEC_W'(1));
         end
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         RA_ENABLE:  reg_rdata_o[NSRC-1:0]  = en_q;
         RA_REQUEST: reg_rdata_o[NSRC-1:0]  = req_q;
         RA_EDGE:    reg_rdata_o[N_SEL-1:0] = sel_q;
         default:    reg_rdata_o[0]         = i_flag_q;
      endcase
   end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
   parameter int NSRC  = 23,
   parameter int VEC_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_ack,
   input logic             irq_pend,
   input logic             irq_take,
   input logic [VEC_W-1:0] irq_vec,
   input logic             i_flag,
   input logic             brk_q,
   input logic [NSRC-1:0]  req_q,
   input logic [NSRC-1:0]  hw_set
);
   p_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && irq_pend) |=> irq_take);

   p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && irq_pend) |=> !irq_take);

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> i_flag);

   p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !brk_q) |-> !i_flag);

   p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_q & ~$past(req_q) & ~$past(hw_set)) == '0));

   p_brk_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && $past(brk_q)) |-> (irq_vec == '0));

   p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (irq_vec <= VEC_W'(NSRC)));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_ack  (cpu_ack_i),
   .irq_pend (irq_pend_o),
   .irq_take (irq_take_o),
   .irq_vec  (irq_vec_o),
   .i_flag   (i_flag_q),
   .brk_q    (brk_q),
   .req_q    (req_q),
   .hw_set   (hw_set)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  ext_pin = '0;
   logic [17:0] int_evt = '0;
   logic        brk = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ack = 1'b0;
   logic        pend, take;
   logic [4:0]  vec;

   int checks = 0;
   int errors = 0;

   always #(CLK_P / 2) clk = ~clk;

   irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .int_evt_i(int_evt),
      .brk_i(brk), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .cpu_ack_i(ack), .irq_pend_o(pend),
      .irq_take_o(take), .irq_vec_o(vec)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse_evt(input int k);
      int_evt[k] = 1'b1;
      @(negedge clk);
      int_evt = '0;
   endtask

   task automatic accept;
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(0, v); check("R1 enables", v, 0);
      rd(1, v); check("R1 requests", v, 0);
      rd(2, v); check("R1 edge select", v, 0);
      rd(3, v); check("R1 disable flag", v, 1);
      check("R1 pend", pend, 0);
      check("R1 take", take, 0);
   endtask

   task automatic t_strobe_and_clear;
      logic [31:0] v;
      pulse_evt(3);
      rd(1, v); check("R2 strobe sets bit 8", v, 32'h100);
      check("R6 masked not pending", pend, 0);
      wr(1, 32'hFFFF_FFFF);
      rd(1, v); check("R4 write of ones sets nothing", v, 32'h100);
      wr(1, ~32'h100);
      rd(1, v); check("R4 write of zero clears", v, 0);
      // R5: event and clear in the same cycle
      int_evt[0] = 1'b1;
      we = 1'b1; addr = 1; wdata = 32'h0;
      @(negedge clk);
      int_evt = '0; we = 1'b0;
      rd(1, v); check("R5 hardware set wins", v, 32'h20);
      wr(1, 0);
   endtask

   task automatic t_pins;
      logic [31:0] v;
      ext_pin[0] = 1'b1;
      cyc(2);
      rd(1, v); check("R3 rise not early", v, 0);
      cyc(1);
      rd(1, v); check("R3 rise on third edge", v, 32'h1);
      wr(1, 0);
      ext_pin[0] = 1'b0;
      cyc(4);
      rd(1, v); check("R3 fall ignored when rising selected", v, 0);
      // R9: pin 1 held low, switch it to falling
      wr(2, 32'h2);
      rd(1, v); check("R9 not before second edge", v, 0);
      cyc(1);
      rd(1, v); check("R9 spurious request from edge select", v, 32'h2);
      wr(1, ~32'h2);
      rd(1, v); check("R4 clear spurious", v, 0);
      ext_pin[1] = 1'b1;
      cyc(4);
      rd(1, v); check("R3 rise ignored when falling selected", v, 0);
      ext_pin[1] = 1'b0;
      cyc(2);
      rd(1, v); check("R3 fall not early", v, 0);
      cyc(1);
      rd(1, v); check("R3 fall on third edge", v, 32'h2);
      wr(1, 0);
      wr(2, 0);
      cyc(3);
      wr(1, 0);
   endtask

   task automatic t_mask_prio;
      logic [31:0] v;
      pulse_evt(0);
      pulse_evt(3);
      wr(0, 32'h120);
      check("R6 disable flag masks", pend, 0);
      wr(3, 0);
      check("R6 enabled and unmasked pending", pend, 1);
      wr(0, 0);
      check("R6 enables mask", pend, 0);
      wr(0, 32'h120);
      accept();
      check("R8 take pulse", take, 1);
      check("R7 lowest index wins", vec, 6);
      rd(1, v); check("R8 winner cleared only", v, 32'h100);
      rd(3, v); check("R8 disable flag set", v, 1);
      check("R6 pend drops after accept", pend, 0);
      cyc(1);
      check("R8 take lasts one cycle", take, 0);
      wr(3, 0);
      accept();
      check("R7 next source vector", vec, 9);
      rd(1, v); check("R8 second winner cleared", v, 0);
   endtask

   task automatic t_break;
      logic [31:0] v;
      pulse_evt(1);
      wr(0, 32'h40);
      brk = 1'b1;
      @(negedge clk);
      brk = 1'b0;
      check("R6 break ignores disable flag", pend, 1);
      wr(3, 0);
      accept();
      check("R8 break take", take, 1);
      check("R7 break outranks request", vec, 0);
      rd(1, v); check("R7 request kept behind break", v, 32'h40);
      check("R8 break latch cleared", pend, 0);
      wr(3, 0);
      accept();
      check("R7 vector after break", vec, 7);
   endtask

   task automatic t_noack;
      logic [31:0] v;
      check("R10 nothing pending", pend, 0);
      wr(3, 0);
      accept();
      check("R10 no take without pending", take, 0);
      rd(3, v); check("R10 flag untouched", v, 0);
      rd(1, v); check("R10 requests untouched", v, 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_strobe_and_clear();
      t_pins();
      t_mask_prio();
      t_break();
      t_noack();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule